// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block runs one port of up to 32 I/O lines. Software programs it through a small synchronous register bus. Each line belongs either to the general-purpose logic or to one of two peripheral functions, and software picks the owner per line. Lines can drive their output push-pull or open-drain, and each has its own pull-up control. On the input side the pads are synchronised, can be passed through a glitch filter, and feed a live level register and a change-detect interrupt.

Every attribute lives in one state register. Software changes it through a write-one-to-set address and a write-one-to-clear address, so one write can raise or lower any group of lines with no read-modify-write. Attribute k occupies three addresses: 3k sets, 3k+1 clears and 3k+2 reads the status. The attributes, in order of k, are:

- 0: ownership (1 = general-purpose logic)
- 1: output enable
- 2: glitch filter
- 3: output value
- 4: interrupt enable
- 5: multi-drive (open-drain)
- 6: pull-up
- 7: peripheral select (0 = function A, 1 = function B)

Address 24 reads the sampled pin levels and address 25 reads the interrupt status. The bus has no back-pressure: a write takes effect at the clock edge where `bus_we` is high, and read data is valid in the same cycle as the address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every implemented line is owned by the general-purpose logic, with pull-up on. Output enable, output value, filter, interrupt enable, multi-drive and peripheral select are all zero, and `irq` is low.
- R2: A write to a set address ORs `bus_wdata` into that attribute, and a write to a clear address removes the 1 bits from it. Bits written as 0 leave their lines unchanged. The status address returns the attribute.
- R3: On a line owned by the general-purpose logic with multi-drive off, `pad_out` equals the output-value bit and `pad_oe` equals the output-enable bit.
- R4: On a line not owned by the general-purpose logic, the pad takes its value and enable from function A when the select bit is 0 and from function B when it is 1.
- R5: With multi-drive set, `pad_out` is 0 and `pad_oe` is high only when the selected drive value is 0 and its enable is 1.
- R6: With the filter off, a pad level appears at the pin-level address three clock edges after it is presented, whoever owns the line.
- R7: With the filter on, a level reaches the pin-level register only after two consecutive synchronised samples agree, which is one edge later than an unfiltered line. A pulse of one cycle is never seen.
- R8: A change of a line's sampled level sets its interrupt-status bit whatever the enable. Reading address 25 returns the bits and clears them. `irq` is high exactly while some pending bit is enabled.
- R9: Bit positions at or above NUM_LINES read as 0, and writes to them have no effect.
- R10: `pad_pu` follows the pull-up attribute.
- R11: Set and clear addresses, and addresses above 25, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for clear-on-read) |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | NUM_LINES | Level seen at each pad |
| pad_out | output | NUM_LINES | Pad drive value |
| pad_oe | output | NUM_LINES | Pad drive enable |
| pad_pu | output | NUM_LINES | Pull-up enable per pad |
| fa_out | input | NUM_LINES | Function A drive value |
| fa_oe | input | NUM_LINES | Function A drive enable |
| fb_out | input | NUM_LINES | Function B drive value |
| fb_oe | input | NUM_LINES | Function B drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the controller with NUM_LINES = 22, a port narrower than the 32-bit bus. This puts the masking of upper write bits and the zero upper read bits within reach. A table-driven pass covers the reset values and the set and clear behaviour. Directed tests then place two low lines under each peripheral function, turn on open-drain, and run a one-cycle pulse and a held level side by side on a filtered line and an unfiltered line. These tests show the one-edge filter delay and the interrupt's clear-on-read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int N_ATTR  = 8;

  // attribute indices; addresses are 3k (set), 3k+1 (clear), 3k+2 (status)
  localparam int AT_OWN = 0;
  localparam int AT_OE  = 1;
  localparam int AT_FLT = 2;
  localparam int AT_OUT = 3;
  localparam int AT_IEN = 4;
  localparam int AT_MD  = 5;
  localparam int AT_PU  = 6;
  localparam int AT_SEL = 7;

  // attributes that come out of reset as all ones
  localparam logic [N_ATTR-1:0] RST_ONES = (N_ATTR'(1) << AT_OWN) | (N_ATTR'(1) << AT_PU);

  localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(3 * N_ATTR);
  localparam logic [ADDR_W-1:0] ISR_ADDR = ADDR_W'(3 * N_ATTR + 1);

  function automatic logic [ADDR_W-1:0] set_addr(input int k);
    return ADDR_W'(3 * k);
  endfunction
  function automatic logic [ADDR_W-1:0] clr_addr(input int k);
    return ADDR_W'(3 * k + 1);
  endfunction
  function automatic logic [ADDR_W-1:0] stat_addr(input int k);
    return ADDR_W'(3 * k + 2);
  endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;
  assign set_m = set_en ? bits : '0;
  assign clr_m = clr_en ? bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= (q | set_m) & ~clr_m;
  end
endmodule

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] filt_en,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] meta_q, sync_q, prev_q, lvl_q, lvl_nxt;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (filt_en[i]) lvl_nxt[i] = (sync_q[i] == prev_q[i]) ? sync_q[i] : lvl_q[i];
      else            lvl_nxt[i] = sync_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      lvl_q  <= lvl_nxt;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
  assign lvl_o  = lvl_q;
  assign chg_o  = lvl_nxt ^ lvl_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int N = 32
) (
  input  logic [N-1:0] own_gp,
  input  logic [N-1:0] sel_b,
  input  logic [N-1:0] md,
  input  logic [N-1:0] gp_out,
  input  logic [N-1:0] gp_oe,
  input  logic [N-1:0] fa_out,
  input  logic [N-1:0] fa_oe,
  input  logic [N-1:0] fb_out,
  input  logic [N-1:0] fb_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic val, en;
    assign val = own_gp[i] ? gp_out[i] : (sel_b[i] ? fb_out[i] : fa_out[i]);
    assign en  = own_gp[i] ? gp_oe[i]  : (sel_b[i] ? fb_oe[i]  : fa_oe[i]);
    assign pad_out[i] = md[i] ? 1'b0 : val;
    assign pad_oe[i]  = md[i] ? (en & ~val) : en;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] pad_pu,
  input  logic [NUM_LINES-1:0] fa_out,
  input  logic [NUM_LINES-1:0] fa_oe,
  input  logic [NUM_LINES-1:0] fb_out,
  input  logic [NUM_LINES-1:0] fb_oe,
  output logic                 irq
);
  localparam int N = NUM_LINES;

  logic [N-1:0] attr_q [N_ATTR];
  logic [N-1:0] wbits;
  assign wbits = bus_wdata[N-1:0];

  for (genvar k = 0; k < N_ATTR; k++) begin : g_attr
    gpio_setclr_reg #(
      .W       (N),
      .RST_VAL (RST_ONES[k] ? {N{1'b1}} : {N{1'b0}})
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (bus_we && bus_addr == set_addr(k)),
      .clr_en (bus_we && bus_addr == clr_addr(k)),
      .bits   (wbits),
      .q      (attr_q[k])
    );
  end

  logic [N-1:0] own_q, oe_q, filt_q, out_q, ien_q, md_q, pu_q, sel_q;
  assign own_q  = attr_q[AT_OWN];
  assign oe_q   = attr_q[AT_OE];
  assign filt_q = attr_q[AT_FLT];
  assign out_q  = attr_q[AT_OUT];
  assign ien_q  = attr_q[AT_IEN];
  assign md_q   = attr_q[AT_MD];
  assign pu_q   = attr_q[AT_PU];
  assign sel_q  = attr_q[AT_SEL];

  logic [N-1:0] sync_q, prev_q, lvl_q, chg;
  gpio_in_stage #(.N(N)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .filt_en (filt_q),
    .sync_o  (sync_q),
    .prev_o  (prev_q),
    .lvl_o   (lvl_q),
    .chg_o   (chg)
  );

  gpio_pad_mux #(.N(N)) u_mux (
    .own_gp  (own_q),
    .sel_b   (sel_q),
    .md      (md_q),
    .gp_out  (out_q),
    .gp_oe   (oe_q),
    .fa_out  (fa_out),
    .fa_oe   (fa_oe),
    .fb_out  (fb_out),
    .fb_oe   (fb_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
  assign pad_pu = pu_q;

  // interrupt status: sticky, cleared by a read of its address
  logic [N-1:0] isr_q;
  logic         isr_rd;
  assign isr_rd = bus_re && bus_addr == ISR_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_rd ? '0 : isr_q) | chg;
  end
  assign irq = |(isr_q & ien_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < N_ATTR; k++)
      if (bus_addr == stat_addr(k)) bus_rdata[N-1:0] = attr_q[k];
    if (bus_addr == PIN_ADDR) bus_rdata[N-1:0] = lvl_q;
    if (bus_addr == ISR_ADDR) bus_rdata[N-1:0] = isr_q;
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N-1:0]      oe_q,
  input logic [N-1:0]      md_q,
  input logic [N-1:0]      filt_q,
  input logic [N-1:0]      sync_q,
  input logic [N-1:0]      prev_q,
  input logic [N-1:0]      lvl_q,
  input logic [N-1:0]      isr_q,
  input logic [N-1:0]      pad_out,
  input logic [N-1:0]      pad_oe
);
  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(oe_q));

  // R5
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & pad_oe & md_q) == '0);

  // R6
  pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lvl_q ^ $past(sync_q)) & ~$past(filt_q)) == '0);

  // R7
  filter_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lvl_q ^ $past(lvl_q)) & $past(filt_q) & ($past(sync_q) ^ $past(prev_q))) == '0);

  // R8
  isr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_re && bus_addr == ISR_ADDR) |=> ($past(isr_q) & ~isr_q) == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_addr (bus_addr),
  .oe_q     (oe_q),
  .md_q     (md_q),
  .filt_q   (filt_q),
  .sync_q   (sync_q),
  .prev_q   (prev_q),
  .lvl_q    (lvl_q),
  .isr_q    (isr_q),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NL    = 22;
  localparam logic [31:0] ALL = 32'h003F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic [NL-1:0] fa_out = 22'h5, fa_oe = 22'hF, fb_out = 22'hA, fb_oe = 22'h4;
  logic          irq;

  int total = 0, failed = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_port_ctrl #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .fa_out(fa_out), .fa_oe(fa_oe), .fb_out(fb_out), .fb_oe(fb_oe), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd2,  32'h0, ALL},            // R1 ownership
    '{1'b0, 5'd5,  32'h0, 32'h0},          // R1 output enable
    '{1'b0, 5'd20, 32'h0, ALL},            // R1 pull-up
    '{1'b0, 5'd14, 32'h0, 32'h0},          // R1 irq enable
    '{1'b0, 5'd8,  32'h0, 32'h0},          // R1 filter
    '{1'b0, 5'd17, 32'h0, 32'h0},          // R1 multi-drive
    '{1'b0, 5'd23, 32'h0, 32'h0},          // R1 select
    '{1'b0, 5'd11, 32'h0, 32'h0},          // R1 output value
    '{1'b1, 5'd3,  32'hFFFF_00F0, 32'h0},  // R2 R9 set oe
    '{1'b0, 5'd5,  32'h0, 32'h003F_00F0},
    '{1'b1, 5'd4,  32'h0000_0030, 32'h0},  // R2 clear oe
    '{1'b0, 5'd5,  32'h0, 32'h003F_00C0},
    '{1'b1, 5'd9,  32'h0000_00A5, 32'h0},
    '{1'b0, 5'd11, 32'h0, 32'h0000_00A5},
    '{1'b1, 5'd10, 32'h0000_0005, 32'h0},
    '{1'b0, 5'd11, 32'h0, 32'h0000_00A0},
    '{1'b0, 5'd4,  32'h0, 32'h0},          // R11 clear address
    '{1'b0, 5'd31, 32'h0, 32'h0},          // R11 unmapped
    '{1'b0, 5'd12, 32'h0, 32'h0}           // R11 set address
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog got %h exp %h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pad_oe", 32'(pad_oe), 32'h0);
    check("R1 pad_pu", 32'(pad_pu), ALL);
    check("R1 irq", 32'(irq), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, r);
        check($sformatf("R2 R11 vec%0d", i), r, VEC[i].exp);
      end
    end

    // R3 GPIO-owned drive
    @(negedge clk);
    check("R3 pad_oe", 32'(pad_oe), 32'h003F_00C0);
    check("R3 pad_out", 32'(pad_out), 32'h0000_00A0);

    // R10 pull-up
    wr(5'd19, 32'h0000_000F);
    check("R10 pad_pu", 32'(pad_pu), 32'h003F_FFF0);

    // R5 open drain
    wr(5'd15, 32'h0000_00C0);
    check("R5 pad_oe", 32'(pad_oe), 32'h003F_0040);
    check("R5 pad_out", 32'(pad_out), 32'h0000_0020);
    wr(5'd16, 32'h0000_00C0);

    // R4 peripheral ownership: lines 0,1 -> A, lines 2,3 -> B
    wr(5'd1, 32'h0000_000F);
    wr(5'd21, 32'h0000_000C);
    check("R4 pad_out", 32'(pad_out), 32'h0000_00A9);
    check("R4 pad_oe", 32'(pad_oe), 32'h003F_00C7);
    rd(5'd2, r);  check("R4 own", r, 32'h003F_FFF0);
    rd(5'd23, r); check("R4 sel", r, 32'h0000_000C);

    // R6 pin level, R8 status set without enable
    @(negedge clk); pad_in = 22'h155555;
    repeat (5) @(negedge clk);
    rd(5'd24, r); check("R6 pin", r, 32'h0015_5555);
    check("R8 irq masked", 32'(irq), 32'h0);
    rd(5'd25, r); check("R8 isr", r, 32'h0015_5555);
    rd(5'd25, r); check("R8 isr cleared", r, 32'h0);

    // R8 enabled interrupt
    wr(5'd12, 32'h0000_0001);
    @(negedge clk); pad_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 irq high", 32'(irq), 32'h1);
    rd(5'd25, r); check("R8 isr bit0", r, 32'h1);
    check("R8 irq low", 32'(irq), 32'h0);

    // R7 one-cycle pulse on filtered line 1 and unfiltered line 3
    wr(5'd6, 32'h0000_0002);
    @(negedge clk); pad_in[1] = 1'b1; pad_in[3] = 1'b1;
    @(negedge clk); pad_in[1] = 1'b0; pad_in[3] = 1'b0;
    repeat (6) @(negedge clk);
    rd(5'd24, r); check("R7 pulse pin", r, 32'h0015_5554);
    rd(5'd25, r); check("R7 pulse isr", r, 32'h0000_0008);

    // R7 held level: filtered line one edge behind
    bus_addr = 5'd24;
    @(negedge clk); pad_in[1] = 1'b1; pad_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 R7 third edge", bus_rdata, 32'h0015_555C);
    @(negedge clk);
    check("R7 fourth edge", bus_rdata, 32'h0015_555E);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule